// File: doc/BRIEF.md
# CAN Fault Confinement Counters

This block holds the two error counters of a CAN node and turns them into the node's confinement state. The protocol engine around it reports events as single-cycle pulses. It reports a transmit error, a receive error, a good transmission, a good reception, and each detected run of eleven recessive bits. The block weights the error pulses and lowers the counters on good traffic. It then classifies the node as error-active, error-passive or bus-off.

Software or a protocol engine reads the counter values and the level-sensitive flags at any time. The warning flag gives early notice, inside the active range, that a counter is climbing. A one-cycle state interrupt marks every move between the three states. While in bus-off, the node is taken off the bus: the counters ignore all traffic events. Only runs of recessive bits are counted, and enough of them bring the node back with clean counters.

Top module: `can_err_confine`

## Requirements
- R1: Outside bus-off, a pulse on `rxErr` raises `rxErrCnt` by 1 at the next clock edge.
- R2: Outside bus-off, a pulse on `txErr` raises `txErrCnt` by 8 at the next clock edge.
- R3: Outside bus-off, a pulse on `txOk` lowers `txErrCnt` by 1 and a pulse on `rxOk` lowers `rxErrCnt` by 1. A counter already at 0 stays at 0.
- R4: When an error pulse and a good-message pulse for the same counter arrive in one cycle, only the error weight is applied. The transmit and receive counters update independently in the same cycle.
- R5: `warnFlag` is high exactly while either counter is 96 or more. It changes in the same cycle as the counter.
- R6: The flags `errActive`, `errPassive` and `busOff` are one-hot, and they take their new value one clock after the counters change. Active means both counters are 127 or less. Passive means either counter is in 128..255 and neither is 256 or more. Bus-off means either counter is 256 or more.
- R7: While either counter is 256 or more, error and good-message pulses leave both counters unchanged.
- R8: In bus-off, the 128th `recessive11` pulse clears both counters and the run count at the next edge. `recessive11` pulses outside bus-off are not counted and change nothing.
- R9: `stateIrq` is high for the cycle in which the state flags first show a new state, and low in every other cycle.
- R10: After reset, both counters are 0, `errActive` is 1, the other flags are 0 and `stateIrq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txErr | input | 1 | Transmit error event pulse |
| rxErr | input | 1 | Receive error event pulse |
| txOk | input | 1 | Successful transmission pulse |
| rxOk | input | 1 | Successful reception pulse |
| recessive11 | input | 1 | Pulse per detected run of 11 recessive bits |
| txErrCnt | output | 9 | Transmit error counter |
| rxErrCnt | output | 9 | Receive error counter |
| warnFlag | output | 1 | Either counter at or above 96 |
| errActive | output | 1 | Node is error-active |
| errPassive | output | 1 | Node is error-passive |
| busOff | output | 1 | Node is bus-off |
| stateIrq | output | 1 | One-cycle pulse on a state change |

## Verification
An error pulse and a good-message pulse can hit the same counter in one cycle. A transmit event and a receive event can also arrive together and land on the two counters at once. The bench drives txErr with txOk, and rxOk with them, in a single cycle. It expects the transmit counter to gain the full weight of 8 and the receive counter to drop by one. The behavioural model checks this collision on every clock, along with the single-cycle lag between a counter crossing a threshold and the state flags with their interrupt.

// File: rtl/err_confine_pkg.sv
package err_confine_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_PASSIVE = 2'd1,
    ST_BUSOFF  = 2'd2
  } confState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic incTx;
    logic incRx;
    logic decTx;
    logic decRx;
    logic seqStep;
    logic clrAll;
  } confStrobes_t;

endpackage

// File: rtl/err_cnt.sv
module err_cnt #(
  parameter int CNT_W  = 9,
  parameter int WEIGHT = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inc,
  input  logic             dec,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W:0]   WADD = (CNT_W+1)'(WEIGHT);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] nextCnt;

  always_comb begin
    sum     = {1'b0, cnt} + WADD;
    nextCnt = cnt;
    if (clr)                   nextCnt = '0;
    else if (inc)              nextCnt = sum[CNT_W] ? MAXV : sum[CNT_W-1:0];
    else if (dec && cnt != '0) nextCnt = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else       cnt <= nextCnt;
  end
endmodule

// File: rtl/err_confine_dp.sv
module err_confine_dp
  import err_confine_pkg::*;
#(
  parameter int CNT_W       = 9,
  parameter int TX_WEIGHT   = 8,
  parameter int RX_WEIGHT   = 1,
  parameter int WARN_LVL    = 96,
  parameter int PASSIVE_LVL = 128,
  parameter int BUSOFF_LVL  = 256,
  parameter int SEQ_GOAL    = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  confStrobes_t     stb,
  output logic [CNT_W-1:0] tecQ,
  output logic [CNT_W-1:0] recQ,
  output logic             lvlWarn,
  output logic             lvlPassive,
  output logic             lvlBusOff,
  output logic             seqDone
);
  localparam int SEQ_W = (SEQ_GOAL > 2) ? $clog2(SEQ_GOAL) : 1;
  localparam logic [CNT_W-1:0] WARN_C    = CNT_W'(WARN_LVL);
  localparam logic [CNT_W-1:0] PASSIVE_C = CNT_W'(PASSIVE_LVL);
  localparam logic [CNT_W-1:0] BUSOFF_C  = CNT_W'(BUSOFF_LVL);
  localparam logic [SEQ_W-1:0] SEQ_LAST  = SEQ_W'(SEQ_GOAL - 1);

  logic [1:0]       incV, decV;
  logic [CNT_W-1:0] cntV [2];
  logic [SEQ_W-1:0] seqCnt;

  assign incV = {stb.incRx, stb.incTx};
  assign decV = {stb.decRx, stb.decTx};

  // slice 0 = transmit, slice 1 = receive
  for (genvar gi = 0; gi < 2; gi++) begin : g_slice
    localparam int W = (gi == 0) ? TX_WEIGHT : RX_WEIGHT;
    err_cnt #(.CNT_W(CNT_W), .WEIGHT(W)) u_cnt (
      .clk (clk),
      .rstN(rstN),
      .inc (incV[gi]),
      .dec (decV[gi]),
      .clr (stb.clrAll),
      .cnt (cntV[gi])
    );
  end

  assign tecQ = cntV[0];
  assign recQ = cntV[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            seqCnt <= '0;
    else if (stb.clrAll)  seqCnt <= '0;
    else if (stb.seqStep) seqCnt <= seqCnt + 1'b1;
  end

  assign lvlWarn    = (tecQ >= WARN_C) || (recQ >= WARN_C);
  assign lvlBusOff  = (tecQ >= BUSOFF_C) || (recQ >= BUSOFF_C);
  assign lvlPassive = (tecQ >= PASSIVE_C) || (recQ >= PASSIVE_C);
  assign seqDone    = (seqCnt == SEQ_LAST);
endmodule

// File: rtl/err_confine_ctrl.sv
module err_confine_ctrl
  import err_confine_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         txErr,
  input  logic         rxErr,
  input  logic         txOk,
  input  logic         rxOk,
  input  logic         recessive11,
  input  logic         lvlPassive,
  input  logic         lvlBusOff,
  input  logic         seqDone,
  output confStrobes_t stb,
  output confState_t   stateQ,
  output logic         irqQ
);
  confState_t nextState;

  always_comb begin
    stb.incTx   = txErr & ~lvlBusOff;
    stb.incRx   = rxErr & ~lvlBusOff;
    stb.decTx   = txOk & ~txErr & ~lvlBusOff;
    stb.decRx   = rxOk & ~rxErr & ~lvlBusOff;
    stb.seqStep = recessive11 & lvlBusOff;
    stb.clrAll  = recessive11 & lvlBusOff & seqDone;
  end

  always_comb begin
    if (lvlBusOff)       nextState = ST_BUSOFF;
    else if (lvlPassive) nextState = ST_PASSIVE;
    else                 nextState = ST_ACTIVE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_ACTIVE;
      irqQ   <= 1'b0;
    end else begin
      stateQ <= nextState;
      irqQ   <= (nextState != stateQ);
    end
  end
endmodule

// File: rtl/can_err_confine.sv
module can_err_confine
  import err_confine_pkg::*;
#(
  parameter int CNT_W       = 9,
  parameter int TX_WEIGHT   = 8,
  parameter int RX_WEIGHT   = 1,
  parameter int WARN_LVL    = 96,
  parameter int PASSIVE_LVL = 128,
  parameter int BUSOFF_LVL  = 256,
  parameter int SEQ_GOAL    = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txErr,
  input  logic             rxErr,
  input  logic             txOk,
  input  logic             rxOk,
  input  logic             recessive11,
  output logic [CNT_W-1:0] txErrCnt,
  output logic [CNT_W-1:0] rxErrCnt,
  output logic             warnFlag,
  output logic             errActive,
  output logic             errPassive,
  output logic             busOff,
  output logic             stateIrq
);
  confStrobes_t stb;
  confState_t   stateQ;
  logic         lvlPassive, lvlBusOff, seqDone;

  err_confine_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .txErr      (txErr),
    .rxErr      (rxErr),
    .txOk       (txOk),
    .rxOk       (rxOk),
    .recessive11(recessive11),
    .lvlPassive (lvlPassive),
    .lvlBusOff  (lvlBusOff),
    .seqDone    (seqDone),
    .stb        (stb),
    .stateQ     (stateQ),
    .irqQ       (stateIrq)
  );

  err_confine_dp #(
    .CNT_W(CNT_W), .TX_WEIGHT(TX_WEIGHT), .RX_WEIGHT(RX_WEIGHT),
    .WARN_LVL(WARN_LVL), .PASSIVE_LVL(PASSIVE_LVL),
    .BUSOFF_LVL(BUSOFF_LVL), .SEQ_GOAL(SEQ_GOAL)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .tecQ      (txErrCnt),
    .recQ      (rxErrCnt),
    .lvlWarn   (warnFlag),
    .lvlPassive(lvlPassive),
    .lvlBusOff (lvlBusOff),
    .seqDone   (seqDone)
  );

  assign errActive  = (stateQ == ST_ACTIVE);
  assign errPassive = (stateQ == ST_PASSIVE);
  assign busOff     = (stateQ == ST_BUSOFF);
endmodule

// File: rtl/err_confine_chk.sv
module err_confine_chk #(
  parameter int CNT_W      = 9,
  parameter int TX_WEIGHT  = 8,
  parameter int RX_WEIGHT  = 1,
  parameter int BUSOFF_LVL = 256
) (
  input logic             clk,
  input logic             rstN,
  input logic             txErr,
  input logic             rxErr,
  input logic             txOk,
  input logic             rxOk,
  input logic             recessive11,
  input logic [CNT_W-1:0] txErrCnt,
  input logic [CNT_W-1:0] rxErrCnt,
  input logic             warnFlag,
  input logic             errActive,
  input logic             errPassive,
  input logic             busOff,
  input logic             stateIrq
);
  localparam logic [CNT_W-1:0] OFF_C = CNT_W'(BUSOFF_LVL);
  localparam logic [CNT_W-1:0] TXW   = CNT_W'(TX_WEIGHT);
  localparam logic [CNT_W-1:0] RXW   = CNT_W'(RX_WEIGHT);

  logic onLine;
  assign onLine = (txErrCnt < OFF_C) && (rxErrCnt < OFF_C);

  assert_rx_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rxErr && onLine) |=> rxErrCnt == $past(rxErrCnt) + RXW);

  assert_tx_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (txErr && onLine) |=> txErrCnt == $past(txErrCnt) + TXW);

  assert_tx_floor_R3: assert property (@(posedge clk) disable iff (!rstN)
    (txOk && !txErr && txErrCnt == '0) |=> txErrCnt == '0);

  assert_rx_floor_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rxOk && !rxErr && rxErrCnt == '0) |=> rxErrCnt == '0);

  assert_warn_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(warnFlag) |-> ($past(txErr) || $past(rxErr)));

  assert_state_onehot_R6: assert property (@(posedge clk) disable iff (!rstN)
    $countones({errActive, errPassive, busOff}) == 1);

  assert_frozen_tx_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!onLine && !recessive11) |=> $stable(txErrCnt));

  assert_frozen_rx_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!onLine && !recessive11) |=> $stable(rxErrCnt));

  assert_irq_change_R9: assert property (@(posedge clk) disable iff (!rstN)
    stateIrq == ({errActive, errPassive, busOff} != $past({errActive, errPassive, busOff})));
endmodule

bind can_err_confine err_confine_chk #(
  .CNT_W(CNT_W), .TX_WEIGHT(TX_WEIGHT), .RX_WEIGHT(RX_WEIGHT), .BUSOFF_LVL(BUSOFF_LVL)
) u_chk (.*);

// File: tb/tb_can_err_confine.sv
`timescale 1ns/1ps
module tb_can_err_confine;
  localparam int CLK_P = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txErr = 0, rxErr = 0, txOk = 0, rxOk = 0, recessive11 = 0;
  logic [8:0] txErrCnt, rxErrCnt;
  logic       warnFlag, errActive, errPassive, busOff, stateIrq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int mTec = 0, mRec = 0, mSeq = 0, mState = 0;
  bit mIrq = 0;

  always #(CLK_P/2) clk = ~clk;

  can_err_confine dut (
    .clk(clk), .rstN(rstN), .txErr(txErr), .rxErr(rxErr), .txOk(txOk),
    .rxOk(rxOk), .recessive11(recessive11), .txErrCnt(txErrCnt),
    .rxErrCnt(rxErrCnt), .warnFlag(warnFlag), .errActive(errActive),
    .errPassive(errPassive), .busOff(busOff), .stateIrq(stateIrq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  function automatic int classify(input int t, input int r);
    if (t >= 256 || r >= 256) return 2;
    if (t >= 128 || r >= 128) return 1;
    return 0;
  endfunction

  // behavioural model: advanced at each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mTec = 0; mRec = 0; mSeq = 0; mState = 0; mIrq = 0;
    end else begin
      int ns;
      ns = classify(mTec, mRec);
      mIrq = (ns != mState);
      mState = ns;
      if (mTec >= 256 || mRec >= 256) begin
        if (recessive11) begin
          if (mSeq == 127) begin mTec = 0; mRec = 0; mSeq = 0; end
          else mSeq++;
        end
      end else begin
        if (txErr) mTec = (mTec + 8 > 511) ? 511 : mTec + 8;
        else if (txOk && mTec > 0) mTec--;
        if (rxErr) mRec = (mRec + 1 > 511) ? 511 : mRec + 1;
        else if (rxOk && mRec > 0) mRec--;
      end
    end
  end

  // compare on every clock, at the falling edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R2 txErrCnt", txErrCnt, mTec);
      check("R1 rxErrCnt", rxErrCnt, mRec);
      check("R5 warnFlag", warnFlag, (mTec >= 96 || mRec >= 96));
      check("R6 state flags", {errActive, errPassive, busOff},
            (mState == 0) ? 3'b100 : (mState == 1) ? 3'b010 : 3'b001);
      check("R9 stateIrq", stateIrq, mIrq);
    end
  end

  task automatic step(input bit te, input bit re, input bit to, input bit ro, input bit r11);
    @(posedge clk); #5;
    txErr = te; rxErr = re; txOk = to; rxOk = ro; recessive11 = r11;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic finishRun();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    // R10 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 tec reset", txErrCnt, 0);
    check("R10 rec reset", rxErrCnt, 0);
    check("R10 active reset", {errActive, errPassive, busOff, stateIrq}, 4'b1000);
    #3 rstN = 1;

    repeat (3) step(0, 1, 0, 0, 0);
    repeat (2) step(1, 0, 0, 0, 0);
    idle(1); @(negedge clk);
    check("R1 rec after 3 errors", rxErrCnt, 3);
    check("R2 tec after 2 errors", txErrCnt, 16);

    // R4: same-cycle error and good message on tx, good message on rx
    step(1, 0, 1, 1, 0);
    idle(1); @(negedge clk);
    check("R4 tec error wins", txErrCnt, 24);
    check("R4 rec independent", rxErrCnt, 2);

    // R3: decrement floors at zero
    repeat (4) step(0, 0, 0, 1, 0);
    idle(1); @(negedge clk);
    check("R3 rec floor", rxErrCnt, 0);

    // R8: recessive runs outside bus-off do nothing
    repeat (3) step(0, 0, 0, 0, 1);
    idle(2); @(negedge clk);
    check("R8 ignored tec", txErrCnt, 24);
    check("R8 ignored active", errActive, 1);

    // R5: warning at 96
    repeat (9) step(1, 0, 0, 0, 0);
    idle(1); @(negedge clk);
    check("R5 warn at 96", warnFlag, 1);

    // R6/R9: passive at 128
    repeat (4) step(1, 0, 0, 0, 0);
    idle(2); @(negedge clk);
    check("R6 passive", errPassive, 1);
    check("R9 irq on passive", stateIrq, 1);

    // back to active, then again up
    step(0, 0, 1, 0, 0);
    idle(2); @(negedge clk);
    check("R6 active at 127", errActive, 1);
    step(1, 0, 0, 0, 0);

    // bus-off: 135 + 16*8 = 263
    repeat (16) step(1, 0, 0, 0, 0);
    idle(2); @(negedge clk);
    check("R6 busoff", busOff, 1);

    // R7: frozen counters
    step(1, 1, 1, 1, 0);
    idle(1); @(negedge clk);
    check("R7 tec frozen", txErrCnt, 263);
    check("R7 rec frozen", rxErrCnt, 0);

    // R8: recovery after 128 runs
    repeat (127) step(0, 0, 0, 0, 1);
    idle(2); @(negedge clk);
    check("R8 still busoff at 127", busOff, 1);
    step(0, 0, 0, 0, 1);
    idle(1); @(negedge clk);
    check("R8 tec cleared", txErrCnt, 0);
    idle(1); @(negedge clk);
    check("R8 active again", errActive, 1);

    // receive path to passive and back
    repeat (128) step(0, 1, 0, 0, 0);
    idle(2); @(negedge clk);
    check("R6 passive via rec", errPassive, 1);
    step(0, 0, 0, 1, 0);
    idle(2); @(negedge clk);
    check("R6 active via rec", errActive, 1);

    idle(4);
    @(negedge clk);
    finishRun();
  end
endmodule